// File: doc/BRIEF.md
# Clock Postscaler with Doze Control

This block sits in the clock tree of a small controller. It takes the fast internal oscillator clock and produces two clock-enable strobes. The system strobe marks the oscillator cycles on which the divided system clock ticks. The CPU strobe is a thinned copy of the system strobe. Peripherals use the system strobe, and the processor core uses the CPU strobe. A single 16-bit control word, written over a plain write port and always visible on a read port, selects both ratios.

The postscaler divides the oscillator by a power of two from 1 to 64, or by 256 at its top setting. No divide-by-128 setting exists. The optional doze ratio keeps one system tick in every 2^n for the CPU. It applies only while the doze-enable field is set. When the recovery flag is set, an interrupt pulse makes the hardware clear doze-enable, so the CPU runs at full system speed again.

Each divider is a two-state machine with the states RELOAD and RUN. Reset enters RELOAD. RELOAD always moves to RUN on the next cycle (transition START). RUN moves back to RELOAD when the selected code differs from the code the counter is running (transition RESELECT). The control word holds a doze-mode machine with the states DOZE_OFF and DOZE_ON. Its transitions are ENTER (a write sets doze-enable and no recovering interrupt is present), CLEAR_WR (a write clears doze-enable) and RECOVER (the recovery flag is set and the interrupt input is high).

Top module: `clk_postscaler_doze`

## Requirements
- R1: The control word fields are: bit 15 recovery flag, bits 14:12 doze code, bit 11 doze enable, bits 10:8 postscaler code. A write with wr_en loads bits 15:8 on the next clock edge. Bits 7:0 are ignored on write and read back as zero.
- R2: After reset the control word reads 16'h3100: recovery 0, doze code 3, doze enable 0, postscaler code 1.
- R3: Postscaler codes 0 through 6 give a sys_ce period of 2^code oscillator cycles, and code 7 gives 256. Code 0 holds sys_ce high on every cycle. sys_ce is high for one cycle per period.
- R4: After a write that changes the postscaler code, the cycle that follows the write edge is cycle 1. The first sys_ce then falls in cycle P+2, where P is the new period. No interval shorter than P ever appears.
- R5: With doze enabled, cpu_ce fires once every 2^doze_code sys_ce pulses, so its period is P·2^doze_code oscillator cycles.
- R6: With doze enable at 0, cpu_ce equals sys_ce, whatever the doze code holds.
- R7: cpu_ce is never high in a cycle where sys_ce is low.
- R8: If the stored recovery flag is 1 while irq is high, doze enable reads 0 after the next edge. If the flag is 0, irq changes nothing in the control word.
- R9: If a write that sets doze enable lands in the same cycle as a recovering interrupt, doze enable ends at 0. The recovery flag value used is the one stored before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Write data for the control word |
| irq | input | 1 | Interrupt event, sampled each cycle |
| rd_data | output | 16 | Current control word, low byte zero |
| sys_ce | output | 1 | System clock-enable strobe |
| cpu_ce | output | 1 | CPU clock-enable strobe |

## Verification
The hardest state to reach is a write that sets doze-enable in the same cycle as an interrupt, while a recovery flag stored earlier is armed. The stimulus first writes the flag, then raises wr_en and irq together in one cycle and reads the word back. A second hard case is a code change that lands partway through a count. The vector table is ordered so that every step changes the postscaler code. The bench can then measure the position of the first strobe after each write, as well as the steady period.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int WORD_W      = 16;
    localparam int CODE_W      = 3;
    localparam int HI_LSB      = 8;
    localparam int HI_W        = WORD_W - HI_LSB;
    localparam int RECOVER_BIT = 15;
    localparam int DOZE_LSB    = 12;
    localparam int DOZE_EN_BIT = 11;
    localparam int POST_LSB    = 8;
    localparam int POST_CNT_W  = 8;
    localparam int DOZE_CNT_W  = 7;

    typedef struct packed {
        logic              recover;
        logic [CODE_W-1:0] doze_code;
        logic              doze_en;
        logic [CODE_W-1:0] post_code;
    } ctrl_t;

    localparam logic              RST_RECOVER = 1'b0;
    localparam logic [CODE_W-1:0] RST_DOZE    = 3'd3;
    localparam logic [CODE_W-1:0] RST_POST    = 3'd1;

    typedef enum logic {
        DIV_RELOAD,
        DIV_RUN
    } div_state_t;

    typedef enum logic {
        DOZE_OFF,
        DOZE_ON
    } doze_state_t;

endpackage

// File: rtl/cdz_ctrl_reg.sv
module cdz_ctrl_reg
    import clkdiv_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [HI_W-1:0] wr_hi,
    input  logic            irq,
    output ctrl_t           cfg
);

    localparam int REC_POS  = RECOVER_BIT - HI_LSB;
    localparam int DZ_POS   = DOZE_LSB - HI_LSB;
    localparam int DEN_POS  = DOZE_EN_BIT - HI_LSB;
    localparam int POST_POS = POST_LSB - HI_LSB;

    logic              recover_q;
    logic [CODE_W-1:0] doze_code_q;
    logic [CODE_W-1:0] post_code_q;
    doze_state_t       doze_q;
    doze_state_t       doze_d;
    logic              recover_hit;
    logic              wr_sets_en;
    logic              wr_clrs_en;

    assign recover_hit = recover_q & irq;
    assign wr_sets_en  = wr_en & wr_hi[DEN_POS];
    assign wr_clrs_en  = wr_en & ~wr_hi[DEN_POS];

    // doze-mode state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            doze_q <= DOZE_OFF;
        end else begin
            doze_q <= doze_d;
        end
    end

    // transitions: ENTER, CLEAR_WR, RECOVER
    always_comb begin
        doze_d = doze_q;
        unique case (doze_q)
            DOZE_OFF: begin
                if (wr_sets_en && !recover_hit) begin
                    doze_d = DOZE_ON;
                end
            end
            DOZE_ON: begin
                if (recover_hit) begin
                    doze_d = DOZE_OFF;
                end else if (wr_clrs_en) begin
                    doze_d = DOZE_OFF;
                end
            end
            default: doze_d = DOZE_OFF;
        endcase
    end

    // plain fields of the control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recover_q   <= RST_RECOVER;
            doze_code_q <= RST_DOZE;
            post_code_q <= RST_POST;
        end else if (wr_en) begin
            recover_q   <= wr_hi[REC_POS];
            doze_code_q <= wr_hi[DZ_POS +: CODE_W];
            post_code_q <= wr_hi[POST_POS +: CODE_W];
        end
    end

    // outputs
    always_comb begin
        cfg.recover   = recover_q;
        cfg.doze_code = doze_code_q;
        cfg.doze_en   = (doze_q == DOZE_ON);
        cfg.post_code = post_code_q;
    end

endmodule

// File: rtl/cdz_divider.sv
module cdz_divider
    import clkdiv_pkg::*;
#(
    parameter int               CNT_W   = 8,
    parameter int               SEL_W   = 3,
    parameter logic [SEL_W-1:0] RST_SEL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [SEL_W-1:0] sel,
    input  logic [CNT_W-1:0] term,
    output logic             pulse
);

    div_state_t       state_q;
    div_state_t       state_d;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cnt_q;
    logic             sel_moved;
    logic             at_term;

    assign sel_moved = (sel != sel_q);
    assign at_term   = (cnt_q == term);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DIV_RELOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: START (RELOAD->RUN), RESELECT (RUN->RELOAD)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIV_RELOAD: state_d = DIV_RUN;
            DIV_RUN: begin
                if (sel_moved) begin
                    state_d = DIV_RELOAD;
                end
            end
            default: state_d = DIV_RELOAD;
        endcase
    end

    // counter and captured selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= RST_SEL;
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                DIV_RELOAD: cnt_q <= '0;
                DIV_RUN: begin
                    if (sel_moved) begin
                        sel_q <= sel;
                        cnt_q <= '0;
                    end else if (adv) begin
                        cnt_q <= at_term ? '0 : cnt_q + 1'b1;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // output strobe
    always_comb begin
        pulse = 1'b0;
        unique case (state_q)
            DIV_RELOAD: pulse = 1'b0;
            DIV_RUN:    pulse = adv && !sel_moved && at_term;
            default:    pulse = 1'b0;
        endcase
    end

endmodule

// File: rtl/clk_postscaler_doze.sv
module clk_postscaler_doze
    import clkdiv_pkg::*;
#(
    parameter int POST_W = POST_CNT_W,
    parameter int DOZE_W = DOZE_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              irq,
    output logic [WORD_W-1:0] rd_data,
    output logic              sys_ce,
    output logic              cpu_ce
);

    localparam logic [CODE_W-1:0] TOP_CODE = {CODE_W{1'b1}};

    ctrl_t             cfg;
    logic [POST_W-1:0] post_term;
    logic [DOZE_W-1:0] doze_term;
    logic [CODE_W-1:0] doze_sel;
    logic              unused_low;

    assign unused_low = ^wr_data[HI_LSB-1:0];

    cdz_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .wr_hi (wr_data[WORD_W-1:HI_LSB]),
        .irq   (irq),
        .cfg   (cfg)
    );

    // postscaler terminal count: powers of two, top code jumps to all ones
    always_comb begin
        if (cfg.post_code == TOP_CODE) begin
            post_term = {POST_W{1'b1}};
        end else begin
            post_term = POST_W'((32'd1 << cfg.post_code) - 32'd1);
        end
    end

    // doze ratio collapses to 1:1 when disabled
    assign doze_sel  = cfg.doze_en ? cfg.doze_code : '0;
    assign doze_term = DOZE_W'((32'd1 << doze_sel) - 32'd1);

    cdz_divider #(
        .CNT_W   (POST_W),
        .SEL_W   (CODE_W),
        .RST_SEL (RST_POST)
    ) u_post (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (1'b1),
        .sel   (cfg.post_code),
        .term  (post_term),
        .pulse (sys_ce)
    );

    cdz_divider #(
        .CNT_W   (DOZE_W),
        .SEL_W   (CODE_W),
        .RST_SEL ('0)
    ) u_doze (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (sys_ce),
        .sel   (doze_sel),
        .term  (doze_term),
        .pulse (cpu_ce)
    );

    assign rd_data = {cfg, {HI_LSB{1'b0}}};

endmodule

// File: rtl/clk_postscaler_doze_chk.sv
module clk_postscaler_doze_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_hi,
    input logic       irq,
    input logic [7:0] rd_hi,
    input logic       sys_ce,
    input logic       cpu_ce
);

    logic rec_hit;
    assign rec_hit = rd_hi[7] && irq;

    AST_CPU_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ce |-> sys_ce); // R7

    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rec_hit) |=> (rd_hi == $past(wr_hi))); // R1

    AST_IRQ_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
        rec_hit |=> !rd_hi[3]); // R8

    AST_IRQ_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_hit && wr_en && wr_hi[3]) |=> !rd_hi[3]); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rec_hit) |=> $stable(rd_hi)); // R8

    AST_BYPASS_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_hi[3] && !$past(rd_hi[3]) && !$past(rd_hi[3], 2)) |-> (cpu_ce == sys_ce)); // R6

    AST_DIV1_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_hi[2:0] == 3'd0) && ($past(rd_hi[2:0]) == 3'd0) && ($past(rd_hi[2:0], 2) == 3'd0))
        |-> sys_ce); // R3

endmodule

bind clk_postscaler_doze clk_postscaler_doze_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_hi  (wr_data[15:8]),
    .irq    (irq),
    .rd_hi  (rd_data[15:8]),
    .sys_ce (sys_ce),
    .cpu_ce (cpu_ce)
);

// File: tb/clk_postscaler_doze_bench.sv
`timescale 1ns/1ps
module clk_postscaler_doze_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        irq = 1'b0;
    logic [15:0] rd_data;
    logic        sys_ce;
    logic        cpu_ce;

    int checks = 0;
    int errors = 0;
    int subset_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    clk_postscaler_doze u_clk_postscaler_doze (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .irq     (irq),
        .rd_data (rd_data),
        .sys_ce  (sys_ce),
        .cpu_ce  (cpu_ce)
    );

    typedef struct packed {
        logic [2:0]  post;
        logic        en;
        logic [2:0]  dz;
        logic [15:0] sp;
        logic [15:0] cp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd0, 1'b0, 3'd5, 16'd1,   16'd1},
        '{3'd1, 1'b1, 3'd0, 16'd2,   16'd2},
        '{3'd2, 1'b1, 3'd3, 16'd4,   16'd32},
        '{3'd6, 1'b1, 3'd1, 16'd64,  16'd128},
        '{3'd7, 1'b0, 3'd7, 16'd256, 16'd256},
        '{3'd5, 1'b1, 3'd7, 16'd32,  16'd4096},
        '{3'd3, 1'b1, 3'd2, 16'd8,   16'd32},
        '{3'd4, 1'b1, 3'd6, 16'd16,  16'd1024}
    };

    localparam int LIMIT = 20000;

    // R7 monitor: cpu strobe outside a system strobe
    always @(negedge clk) begin
        if (rst_n && cpu_ce && !sys_ce) subset_bad++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic write_word(input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // cycles until sys_ce, counting the current negedge as 1
    task automatic first_sys(output int n);
        n = 1;
        while (!sys_ce && n < LIMIT) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic next_sys(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sys_ce && n < LIMIT);
    endtask

    task automatic cpu_period(output int n);
        int g = 0;
        while (!cpu_ce && g < LIMIT) begin
            @(negedge clk);
            g++;
        end
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_ce && n < LIMIT);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R2: reset contents, no strobe in reset
        check(rd_data == 16'h3100, "R2 reset word", rd_data, 16'h3100);
        check(!sys_ce && !cpu_ce, "R2 strobes quiet in reset", sys_ce, 0);
        rst_n = 1'b1;
        @(negedge clk);
        next_sys(n);
        next_sys(n);
        check(n == 2, "R3 default divide by 2", n, 2);
        cpu_period(n);
        check(n == 2, "R6 default cpu equals sys", n, 2);

        // vector table: R3 period, R4 first strobe, R5/R6 cpu period
        for (int i = 0; i < 8; i++) begin
            write_word({1'b0, VECS[i].dz, VECS[i].en, VECS[i].post, 8'h00});
            first_sys(n);
            check(n == int'(VECS[i].sp) + 2, "R4 first strobe after code change", n, int'(VECS[i].sp) + 2);
            next_sys(n);
            check(n == int'(VECS[i].sp), "R3 postscaler period", n, int'(VECS[i].sp));
            cpu_period(n);
            check(n == int'(VECS[i].cp), "R5 doze cpu period", n, int'(VECS[i].cp));
        end

        // R1: low byte ignored, fields land
        write_word(16'hA5FF);
        check(rd_data == 16'hA500, "R1 field write and low byte zero", rd_data, 16'hA500);

        // R8: irq with flag 0 leaves doze enabled
        write_word(16'h2B00);
        @(negedge clk);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        check(rd_data == 16'h2B00, "R8 irq without recovery ignored", rd_data, 16'h2B00);
        cpu_period(n);
        check(n == 32, "R8 doze still active", n, 32);

        // R8: irq with flag 1 clears doze enable
        write_word(16'hAB00);
        @(negedge clk);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        check(rd_data == 16'hA300, "R8 recovery clears doze enable", rd_data, 16'hA300);
        cpu_period(n);
        check(n == 8, "R6 ratio back to 1:1 after recovery", n, 8);

        // R9: write setting enable collides with recovering irq
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = 16'hAB00;
        irq     = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        irq   = 1'b0;
        check(rd_data == 16'hA300, "R9 interrupt beats write", rd_data, 16'hA300);

        // R6: doze code with enable clear has no effect
        write_word(16'h7300);
        cpu_period(n);
        check(n == 8, "R6 disabled doze code ignored", n, 8);

        check(subset_bad == 0, "R7 cpu strobe within sys strobe", subset_bad, 0);
        done = 1'b1;
        summary();
    end

endmodule